// File: doc/BRIEF.md
# Instruction Prefetch Queue with Shared Address/Data Bus

This block is the fetch front end of a 16-bit processor. It reads instruction bytes from memory ahead of need and holds them in a six-byte first-in first-out queue. An execution unit removes the bytes one at a time. Bus activity and byte consumption are independent, so a bus transfer can be in flight while bytes leave the queue.

The memory side uses one set of lines for both address and data. Every transfer lasts exactly four clocks. In the first clock the 20-bit address is driven with an address-latch strobe. In the remaining three clocks the lines are released and a read strobe is raised. The read word is taken in at the end of the fourth clock. A flush input with a new address serves taken branches. It empties the queue at once, discards whatever the bus transfer in progress returns, and redirects fetching to the new address.

Top module: `prefetch_queue`

## Requirements
- R1: The queue holds at most 6 bytes. A bus transfer starts only when at least 2 queue entries are free, counting the queue as it stands before this cycle's byte removal. With fewer than 2 free entries, the address strobe stays low.
- R2: A transfer lasts 4 clocks. In clock 1, `ale_o`=1, `bus_ad_oe_o`=1 and `bus_ad_o` carries the fetch address. In clocks 2 to 4, `rd_o`=1, `ale_o`=0 and `bus_ad_oe_o`=0.
- R3: Read data is sampled from `bus_rdata_i` at the clock edge that ends clock 4. Bits [7:0] hold the byte at the even address of the word, and bits [15:8] hold the byte at the odd address.
- R4: A fetch from an even address loads two bytes, lower address first, and the next fetch address is 2 higher, wrapping at 20 bits.
- R5: A fetch from an odd address loads only bits [15:8], and the next fetch address is 1 higher, which is even.
- R6: When space allows, a new transfer starts in the clock right after clock 4. Address strobes are then 4 clocks apart while the execution side keeps removing bytes.
- R7: A one-cycle `flush_i` leaves the queue empty in the next cycle. Bytes from the transfer in progress are dropped. The next address strobe carries `flush_addr_i`, after the current transfer ends, or in the next cycle if the bus is idle.
- R8: `byte_valid_o` is low whenever the queue is empty. A `take_i` pulse while empty removes nothing, so the first byte that later arrives is still delivered.
- R9: After reset, `byte_valid_o`, `ale_o` and `rd_o` are low, and the first fetch address is 0xFFFF0.
- R10: While a byte is valid and neither taken nor flushed, `byte_o` and `byte_valid_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Execution side removes the head byte |
| flush_i | input | 1 | Empty the queue and redirect fetching |
| flush_addr_i | input | 20 | New fetch address used with flush |
| bus_rdata_i | input | 16 | Word read from the shared lines |
| byte_o | output | 8 | Head byte of the queue |
| byte_valid_o | output | 1 | Head byte is present |
| bus_ad_o | output | 20 | Address driven on the shared lines |
| bus_ad_oe_o | output | 1 | Shared lines driven by this block |
| ale_o | output | 1 | Address latch strobe |
| rd_o | output | 1 | Read strobe |

## Verification
A wrong queue pointer or count shows up at `byte_o` on the next removal, as a byte out of address order. A scoreboard that knows every address's content therefore catches it within one byte. A wrong fetch address or a missed realignment after an odd target is seen at the next address strobe, at most four clocks after the transfer in progress. A mistake in the free-space rule shows as a strobe on a queue that is too full. A failure to discard shows as stale bytes right after a flush.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_T1,
        PH_T2,
        PH_T3,
        PH_T4
    } bus_phase_e;
endpackage

// File: rtl/pfq_byte_fifo.sv
module pfq_byte_fifo #(
    parameter int DEPTH = 6,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             pop_i,
    input  logic [1:0]       push_n_i,
    input  logic [7:0]       push_b0_i,
    input  logic [7:0]       push_b1_i,
    output logic [7:0]       head_o,
    output logic             nonempty_o,
    output logic [CNT_W-1:0] free_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PTR_W-1:0]      rd;
        logic [PTR_W-1:0]      wr;
        logic [CNT_W-1:0]      cnt;
    } fifo_t;

    fifo_t s_d, s_q;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic [PTR_W-1:0] wr_next;

    always_comb begin
        s_d     = s_q;
        wr_next = step(s_q.wr);
        if (clear_i) begin
            s_d.rd  = '0;
            s_d.wr  = '0;
            s_d.cnt = '0;
        end else begin
            if (pop_i) begin
                s_d.rd = step(s_q.rd);
            end
            if (push_n_i != 2'd0) begin
                s_d.mem[s_q.wr] = push_b0_i;
                s_d.wr          = wr_next;
            end
            if (push_n_i == 2'd2) begin
                s_d.mem[wr_next] = push_b1_i;
                s_d.wr           = step(wr_next);
            end
            s_d.cnt = s_q.cnt + CNT_W'(push_n_i) - CNT_W'(pop_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head_o     = s_q.mem[s_q.rd];
    assign nonempty_o = (s_q.cnt != '0);
    assign free_o     = CNT_W'(DEPTH) - s_q.cnt;
endmodule

// File: rtl/pfq_bus_seq.sv
module pfq_bus_seq
    import pfq_pkg::*;
#(
    parameter int              ADDR_W     = 20,
    parameter int              DATA_W     = 16,
    parameter int              DEPTH      = 6,
    parameter int              CNT_W      = $clog2(DEPTH + 1),
    parameter logic [ADDR_W-1:0] RESET_ADDR = 20'hFFFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] flush_addr_i,
    input  logic [CNT_W-1:0]  free_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] ad_o,
    output logic              ad_oe_o,
    output logic              ale_o,
    output logic              rd_o,
    output logic [1:0]        push_n_o,
    output logic [7:0]        push_b0_o,
    output logic [7:0]        push_b1_o
);
    localparam int ROOM_W = CNT_W + 1;

    typedef struct packed {
        bus_phase_e        phase;
        logic [ADDR_W-1:0] addr;
        logic              discard;
    } seq_t;

    seq_t s_d, s_q;

    logic             odd;
    logic             keep;
    logic [ROOM_W-1:0] room_after;

    always_comb begin
        s_d        = s_q;
        odd        = s_q.addr[0];
        keep       = !s_q.discard && !flush_i;
        push_n_o   = 2'd0;
        room_after = '0;
        case (s_q.phase)
            PH_IDLE: begin
                if (flush_i || ({1'b0, free_i} >= ROOM_W'(2))) begin
                    s_d.phase = PH_T1;
                end
            end
            PH_T1: s_d.phase = PH_T2;
            PH_T2: s_d.phase = PH_T3;
            PH_T3: s_d.phase = PH_T4;
            PH_T4: begin
                if (keep) begin
                    push_n_o = odd ? 2'd1 : 2'd2;
                    s_d.addr = s_q.addr + (odd ? ADDR_W'(1) : ADDR_W'(2));
                end
                s_d.discard = 1'b0;
                room_after  = {1'b0, free_i} - ROOM_W'(push_n_o);
                if (flush_i || (room_after >= ROOM_W'(2))) begin
                    s_d.phase = PH_T1;
                end else begin
                    s_d.phase = PH_IDLE;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
        if (flush_i) begin
            s_d.addr = flush_addr_i;
            if (s_q.phase == PH_T1 || s_q.phase == PH_T2 || s_q.phase == PH_T3) begin
                s_d.discard = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase   <= PH_IDLE;
            s_q.addr    <= RESET_ADDR;
            s_q.discard <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ale_o     = (s_q.phase == PH_T1);
    assign ad_oe_o   = (s_q.phase == PH_T1);
    assign ad_o      = ad_oe_o ? s_q.addr : '0;
    assign rd_o      = (s_q.phase == PH_T2) || (s_q.phase == PH_T3) || (s_q.phase == PH_T4);
    assign push_b0_o = odd ? rdata_i[DATA_W-1 -: 8] : rdata_i[7:0];
    assign push_b1_o = rdata_i[DATA_W-1 -: 8];
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
    parameter int                ADDR_W     = 20,
    parameter int                DATA_W     = 16,
    parameter int                DEPTH      = 6,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 20'hFFFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] flush_addr_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic [7:0]        byte_o,
    output logic              byte_valid_o,
    output logic [ADDR_W-1:0] bus_ad_o,
    output logic              bus_ad_oe_o,
    output logic              ale_o,
    output logic              rd_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] free;
    logic [1:0]       push_n;
    logic [7:0]       push_b0;
    logic [7:0]       push_b1;
    logic             nonempty;
    logic             pop;

    assign pop = take_i && nonempty && !flush_i;

    pfq_byte_fifo #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (flush_i),
        .pop_i      (pop),
        .push_n_i   (push_n),
        .push_b0_i  (push_b0),
        .push_b1_i  (push_b1),
        .head_o     (byte_o),
        .nonempty_o (nonempty),
        .free_o     (free)
    );

    pfq_bus_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .DEPTH      (DEPTH),
        .CNT_W      (CNT_W),
        .RESET_ADDR (RESET_ADDR)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .flush_addr_i (flush_addr_i),
        .free_i       (free),
        .rdata_i      (bus_rdata_i),
        .ad_o         (bus_ad_o),
        .ad_oe_o      (bus_ad_oe_o),
        .ale_o        (ale_o),
        .rd_o         (rd_o),
        .push_n_o     (push_n),
        .push_b0_o    (push_b0),
        .push_b1_o    (push_b1)
    );

    assign byte_valid_o = nonempty;
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              take_i,
    input logic              flush_i,
    input logic [7:0]        byte_o,
    input logic              byte_valid_o,
    input logic [ADDR_W-1:0] bus_ad_o,
    input logic              bus_ad_oe_o,
    input logic              ale_o,
    input logic              rd_o
);
    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !ale_o); // R2
    AST_RD_FOLLOWS_ALE: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> rd_o); // R2
    AST_LINES_FREE_ON_RD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o |-> (!bus_ad_oe_o && !ale_o)); // R2
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !byte_valid_o); // R7
    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_o && !take_i && !flush_i) |=> (byte_valid_o && $stable(byte_o))); // R10
    AST_ADDR_ONLY_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ad_oe_o |-> (bus_ad_o == '0)); // R2
endmodule

bind prefetch_queue pfq_checker #(.ADDR_W(ADDR_W)) u_pfq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .take_i       (take_i),
    .flush_i      (flush_i),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .bus_ad_o     (bus_ad_o),
    .bus_ad_oe_o  (bus_ad_oe_o),
    .ale_o        (ale_o),
    .rd_o         (rd_o)
);

// File: tb/prefetch_queue_bench.sv
module prefetch_queue_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take_i = 1'b0;
    logic        flush_i = 1'b0;
    logic [19:0] flush_addr_i = '0;
    logic [15:0] bus_rdata_i = '0;
    logic [7:0]  byte_o;
    logic        byte_valid_o;
    logic [19:0] bus_ad_o;
    logic        bus_ad_oe_o;
    logic        ale_o;
    logic        rd_o;

    always #2 clk = ~clk;

    prefetch_queue u_prefetch_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_i       (take_i),
        .flush_i      (flush_i),
        .flush_addr_i (flush_addr_i),
        .bus_rdata_i  (bus_rdata_i),
        .byte_o       (byte_o),
        .byte_valid_o (byte_valid_o),
        .bus_ad_o     (bus_ad_o),
        .bus_ad_oe_o  (bus_ad_oe_o),
        .ale_o        (ale_o),
        .rd_o         (rd_o)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0]  exp_q[$];
    logic [19:0] exp_fa = 20'hFFFF0;
    logic [19:0] lat = '0;
    int          rd_left = 0;
    int          gap = 0;
    int          ale_count = 0;
    int          taken = 0;
    bit          saw_b2b = 0;
    bit          take_en = 0;
    bit          force_take = 0;
    bit          flush_req = 0;
    logic [19:0] flush_req_addr = '0;
    bit          chk_empty = 0;

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return a[7:0] + (a[15:8] * 8'd3) + {4'h0, a[19:16]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_expected(input logic [19:0] a);
        exp_q.delete();
        for (int i = 0; i < 400; i++) begin
            exp_q.push_back(mem_byte(a + 20'(i)));
        end
    endtask

    // driver and monitor: all bench-side sampling and driving at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            gap++;
            if (chk_empty) begin
                chk(!byte_valid_o, "R7 queue empty after flush", byte_valid_o, 0);
                chk_empty = 0;
            end
            if (ale_o) begin
                chk(bus_ad_oe_o && !rd_o, "R2 clock 1 strobes", {bus_ad_oe_o, rd_o}, 2'b10);
                chk(bus_ad_o == exp_fa, "R4 R5 R7 fetch address", bus_ad_o, exp_fa);
                lat = bus_ad_o;
                exp_fa = lat[0] ? lat + 20'd1 : lat + 20'd2;
                ale_count++;
                if (gap == 4) saw_b2b = 1;
                gap = 0;
                rd_left = 3;
            end else if (rd_left > 0) begin
                chk(rd_o && !bus_ad_oe_o, "R2 clocks 2-4 strobes", {rd_o, bus_ad_oe_o}, 2'b10);
                rd_left--;
            end
            bus_rdata_i = {mem_byte({lat[19:1], 1'b1}), mem_byte({lat[19:1], 1'b0})};

            if (flush_req) begin
                flush_i      <= 1'b1;
                flush_addr_i <= flush_req_addr;
                exp_fa = flush_req_addr;
                load_expected(flush_req_addr);
                take_i       <= 1'b0;
                chk_empty = 1;
                flush_req = 0;
            end else begin
                flush_i <= 1'b0;
                if (byte_valid_o && exp_q.size() > 0 && !take_en) begin
                    chk(byte_o == exp_q[0], "R10 head held", byte_o, exp_q[0]);
                end
                if (take_en && byte_valid_o) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R3 scoreboard underrun", 0, 1);
                    end else begin
                        chk(byte_o == exp_q[0], "R3 R4 byte order", byte_o, exp_q[0]);
                        void'(exp_q.pop_front());
                    end
                    taken++;
                    take_i <= 1'b1;
                end else begin
                    take_i <= force_take && !byte_valid_o;
                end
            end
        end
    end

    task automatic do_flush(input logic [19:0] a);
        @(posedge clk);
        flush_req_addr = a;
        flush_req = 1;
        while (flush_req) @(posedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        int base;
        load_expected(20'hFFFF0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!byte_valid_o && !ale_o && !rd_o, "R9 reset outputs", {byte_valid_o, ale_o, rd_o}, 0);
        rst_n = 1'b1;

        // R8: take pulses while empty
        @(posedge clk);
        force_take = 1;
        @(negedge clk);
        chk(!byte_valid_o, "R8 valid low when empty", byte_valid_o, 0);
        @(posedge clk);
        @(posedge clk);
        force_take = 0;
        @(negedge clk);
        chk(!byte_valid_o, "R8 still empty", byte_valid_o, 0);

        // R6: continuous consumption, back-to-back transfers
        @(posedge clk);
        take_en = 1;
        idle(60);
        chk(saw_b2b, "R6 back-to-back transfers", saw_b2b, 1);

        // R1: fill without consumption from an even target
        take_en = 0;
        do_flush(20'h40000);
        idle(30);
        base = ale_count;
        idle(20);
        chk(ale_count == base, "R1 no fetch while full", ale_count, base);
        take_en = 1;
        @(posedge clk);
        take_en = 0;
        idle(20);
        chk(ale_count == base, "R1 no fetch with one free", ale_count, base);
        take_en = 1;
        @(posedge clk);
        take_en = 0;
        idle(10);
        chk(ale_count == base + 1, "R1 fetch with two free", ale_count, base + 1);

        // R7 idle-bus flush while full, then R5 odd target during busy bus
        do_flush(20'h20000);
        idle(12);
        take_en = 1;
        idle(20);
        do_flush(20'h12345);
        for (int i = 0; i < 60; i++) begin
            @(posedge clk);
            take_en = (i % 3) != 0;
        end
        take_en = 1;

        // back-to-back flushes: first target's data must never appear
        do_flush(20'h0ABC0);
        do_flush(20'h00007);
        idle(50);

        // R4 address wrap at 20 bits
        do_flush(20'hFFFFD);
        idle(80);
        chk(taken > 100, "R6 bytes consumed", taken, 100);
        take_en = 0;
        idle(4);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule